// File: doc/BRIEF.md
# Timer Overflow Status Flag Register

This block gathers overflow events from eight timers into one 8-bit status register that software polls. Two wide timers and six general timers each drive a single-cycle overflow pulse. The pulse sets that timer's flag, and the flag stays set until software clears it. Software can replace the whole byte or set or clear one flag through a bit index. This lets a polling loop acknowledge overflows one at a time without a read-modify-write race.

While the CPU has a read access open, the flags are frozen. Overflow pulses that arrive in that time go into a pending latch for each bit. The latch is merged into the flags in the first cycle after the access closes, so the event shows on the next read. The general timers also have an interrupt request path. It is a registered copy of their overflow pulses and is fully independent of the status flags and of software writes to them.

Top module: `ovf_flag_reg`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 8'h00 and `irq_ovf` is 6'h00.
- R2: With `acc_rd` low, a high `ovf_pulse[k]` at a rising clock edge sets `rd_data[k]` from that edge on. Bits 7 and 6 belong to the two wide timers (second, first), and bits 5..0 belong to general timers 5..0.
- R3: While `acc_rd` is high at an edge and no write is strobed, `rd_data` does not change at that edge, even if overflow pulses arrive.
- R4: A pulse that arrives while `acc_rd` is high is kept pending. It sets its flag at the first edge where `acc_rd` is low.
- R5: With `wr_byte` high at an edge, all eight flags take `wr_data`, except that any bit set by an overflow in that same cycle stays 1.
- R6: With `wr_bit` high (and `wr_byte` low), flag `bit_idx` (3-bit index) takes `bit_val` (1 = set, 0 = clear), and the other seven flags are unchanged.
- R7: In the same cycle, a hardware overflow set of a bit wins over a software clear of that bit, by either byte write or bit write.
- R8: `irq_ovf[k]` is high in the cycle after `ovf_pulse[k]` is high, for k = 0..5. This holds whatever the state of `acc_rd`, the flags or the write strobes. The wide-timer pulses (bits 7..6) drive no request.
- R9: When `wr_byte` and `wr_bit` are strobed together, the byte write applies and the bit write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovf_pulse | input | 8 | Single-cycle overflow pulses; 7..6 wide timers, 5..0 general timers |
| acc_rd | input | 1 | CPU read access in progress; freezes flag updates from overflows |
| wr_byte | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write value |
| wr_bit | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Index of the flag for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| rd_data | output | 8 | Current flag byte |
| irq_ovf | output | 6 | Overflow interrupt requests of the general timers |

## Verification
A hardware overflow set and a software clear of the same flag can fall in one cycle. The bench provokes this twice. The first time, it issues a bit-clear of a set flag while pulsing that flag's timer. The second time, it writes an all-zero byte while pulsing a wide timer. In both cases it judges the flag value on the next cycle, which must be 1. The bench also lines up a pulse with the cycle in which a read access ends, and with a write made during an access. This confirms that the pending merge, the freeze and the interrupt copy do not disturb one another.

// File: rtl/ovf_flag_reg.sv
module ovf_flag_reg #(
  parameter int NFLAG = 8,
  parameter int NIRQ  = 6,
  localparam int IW   = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ovf_pulse,
  input  logic             acc_rd,
  input  logic             wr_byte,
  input  logic [NFLAG-1:0] wr_data,
  input  logic             wr_bit,
  input  logic [IW-1:0]    bit_idx,
  input  logic             bit_val,
  output logic [NFLAG-1:0] rd_data,
  output logic [NIRQ-1:0]  irq_ovf
);

  logic [NFLAG-1:0] flags, pend, hw_set, sw_next;

  assign hw_set  = acc_rd ? '0 : (ovf_pulse | pend);
  assign rd_data = flags;

  always_comb begin
    sw_next = flags;
    if (wr_byte)
      sw_next = wr_data;
    else if (wr_bit)
      sw_next[bit_idx] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      pend    <= '0;
      irq_ovf <= '0;
    end else begin
      flags   <= sw_next | hw_set;
      pend    <= acc_rd ? (pend | ovf_pulse) : '0;
      irq_ovf <= ovf_pulse[NIRQ-1:0];
    end
  end

endmodule

module ovf_flag_reg_chk #(
  parameter int NFLAG = 8,
  parameter int NIRQ  = 6,
  localparam int IW   = $clog2(NFLAG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] ovf_pulse,
  input logic             acc_rd,
  input logic             wr_byte,
  input logic [NFLAG-1:0] wr_data,
  input logic             wr_bit,
  input logic [IW-1:0]    bit_idx,
  input logic             bit_val,
  input logic [NFLAG-1:0] rd_data,
  input logic [NIRQ-1:0]  irq_ovf
);

  always @(posedge clk)
    if (!rst_n) begin
      a_r1_reset_clear: assert (rd_data == '0 && irq_ovf == '0);
    end

  a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> ((rd_data & $past(ovf_pulse)) == $past(ovf_pulse)));

  a_r3_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !wr_byte && !wr_bit) |=> $stable(rd_data));

  a_r5_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && wr_byte) |=> (rd_data == $past(wr_data)));

  a_r7_hw_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rd && wr_bit && !wr_byte && !bit_val && ovf_pulse[bit_idx]) |=> rd_data[$past(bit_idx)]);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_ovf == $past(ovf_pulse[NIRQ-1:0])));

endmodule

bind ovf_flag_reg ovf_flag_reg_chk #(.NFLAG(NFLAG), .NIRQ(NIRQ)) u_chk (.*);

// File: tb/ovf_flag_reg_bench.sv
`timescale 1ns/1ps
module ovf_flag_reg_bench;
  logic       clk = 0, rst_n = 1;
  logic [7:0] ovf_pulse = 0, wr_data = 0;
  logic       acc_rd = 0, wr_byte = 0, wr_bit = 0, bit_val = 0;
  logic [2:0] bit_idx = 0;
  logic [7:0] rd_data;
  logic [5:0] irq_ovf;
  int n_chk = 0, n_bad = 0;

  ovf_flag_reg u_ovf_flag_reg (.*);

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ovf_pulse = 0; wr_byte = 0; wr_bit = 0; acc_rd = 0;
  endtask

  task automatic set_flags(logic [7:0] v);
    wr_byte = 1; wr_data = v; step(); wr_byte = 0;
  endtask

  task automatic t_reset();
    #2 rst_n = 0;
    step(); step();
    chk("R1 flags", rd_data, 8'h00);
    chk("R1 irq", {2'b0, irq_ovf}, 8'h00);
    rst_n = 1; step();
  endtask

  task automatic t_direct();
    ovf_pulse = 8'h81; step(); ovf_pulse = 0;
    chk("R2 set", rd_data, 8'h81);
    chk("R8 irq", {2'b0, irq_ovf}, 8'h01);
    step();
    chk("R8 irq drop", {2'b0, irq_ovf}, 8'h00);
    chk("R2 sticky", rd_data, 8'h81);
    set_flags(8'h00);
  endtask

  task automatic t_defer();
    acc_rd = 1; step();
    ovf_pulse = 8'h24; step(); ovf_pulse = 0;
    chk("R3 frozen", rd_data, 8'h00);
    chk("R8 irq in read", {2'b0, irq_ovf}, 8'h24);
    step();
    chk("R3 still frozen", rd_data, 8'h00);
    ovf_pulse = 8'h40; step(); ovf_pulse = 0;
    chk("R3 frozen late", rd_data, 8'h00);
    acc_rd = 0; step();
    chk("R4 merged", rd_data, 8'h64);
    acc_rd = 1; step();
    acc_rd = 0; ovf_pulse = 8'h01; step(); ovf_pulse = 0;
    chk("R4 edge pulse", rd_data, 8'h65);
    set_flags(8'h00);
  endtask

  task automatic t_byte();
    acc_rd = 1; ovf_pulse = 8'h02; set_flags(8'hA5); ovf_pulse = 0;
    chk("R5 byte in read", rd_data, 8'hA5);
    acc_rd = 0; step();
    chk("R4 after write", rd_data, 8'hA7);
    set_flags(8'h3C);
    chk("R5 byte", rd_data, 8'h3C);
  endtask

  task automatic t_bit();
    wr_bit = 1; bit_idx = 3'd7; bit_val = 1; step(); wr_bit = 0;
    chk("R6 bit set", rd_data, 8'hBC);
    wr_bit = 1; bit_idx = 3'd2; bit_val = 0; step(); wr_bit = 0;
    chk("R6 bit clear", rd_data, 8'hB8);
  endtask

  task automatic t_prio();
    wr_bit = 1; bit_idx = 3'd3; bit_val = 0; ovf_pulse = 8'h08; step(); idle();
    chk("R7 bit clear loses", rd_data, 8'hB8);
    wr_byte = 1; wr_data = 8'h00; ovf_pulse = 8'h40; step(); idle();
    chk("R7 byte clear loses", rd_data, 8'h40);
    wr_byte = 1; wr_data = 8'h0F; wr_bit = 1; bit_idx = 3'd7; bit_val = 1; step(); idle();
    chk("R9 byte wins", rd_data, 8'h0F);
  endtask

  task automatic t_irq();
    wr_byte = 1; wr_data = 8'hFF; step(); idle();
    chk("R8 no irq on write", {2'b0, irq_ovf}, 8'h00);
    ovf_pulse = 8'hC0; step(); ovf_pulse = 0;
    chk("R8 wide no irq", {2'b0, irq_ovf}, 8'h00);
    wr_byte = 1; wr_data = 8'h00; ovf_pulse = 8'h3F; step(); idle();
    chk("R8 irq with write", {2'b0, irq_ovf}, 8'h3F);
    chk("R7 flags kept", rd_data, 8'h3F);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_defer();
    t_byte();
    t_bit();
    t_prio();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule